// File: doc/BRIEF.md
# Interrupt Summary Aggregator

The block collects pending-interrupt indications from six sub-blocks of a small communications controller and presents them as one summary byte on a simple register read bus. It also drives a single interrupt line. The six sources are a D-channel HDLC controller, a synchronous-transfer timing source, a pair of C/I channel value monitors, a group of four auxiliary sources, a transceiver and a monitor-channel status unit. The sub-block datapaths are not part of this block. Each one is represented by an event pulse, or by the C/I channel values themselves.

Each sub-block has its own second-level status register in this block. These registers are clear-on-read latches. The summary byte only mirrors them, so reading the summary clears nothing. Software reads the summary to find the cause, then reads the matching second-level register. That read clears the latch, and the summary bit falls one cycle later. A per-bit mask gates which summary bits may raise the interrupt line. The mask has no effect on the value that is read back.

Top module: `irq_summary`

## Requirements
- R1: After reset every status latch is clear and the summary (address 0) reads 0x00. The mask (address 8) reads 0xFC, and irq_o is low.
- R2: An event pulse sets its summary bit, which reads 1 in the cycle after the pulse. The bit positions are HDLC 7, synchronous transfer 6, C/I change 5, auxiliary 4, transceiver 3 and monitor 2. Bits 1 and 0 always read 0.
- R3: A read of address 0 changes no status latch.
- R4: A read strobe on a single-source status register clears that latch, and its summary bit reads 0 in the following cycle. The addresses are HDLC 1, synchronous transfer 2, transceiver 6 and monitor 7. During the read, bit 0 of the data shows the latched state and bits 7..1 read 0. Other latches are untouched.
- R5: An event that arrives in the same cycle as the clearing read of its own register wins. The latch stays set.
- R6: The auxiliary register (address 5) latches four sources in bits 0 to 3: wake, watchdog, timer 1 and timer 2. Summary bit 4 is the OR of the four latched bits. One read of address 5 clears all four.
- R7: A change of the value on C/I channel 0 or channel 1 sets that channel's change flag. Addresses 3 and 4 return the flag in bit 7 and the channel's current value in the low bits. Reading a channel's register clears only that channel's flag. Summary bit 5 is the OR of both flags.
- R8: irq_o is high exactly when some summary bit is set and its mask bit is 1. The mask is written at address 8 through wr_en_i. The summary value read back does not depend on the mask.
- R9: Reads of unmapped addresses (9 to 15) return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdlc_evt_i | input | 1 | HDLC controller event pulse |
| sync_evt_i | input | 1 | Synchronous-transfer event pulse |
| trx_evt_i | input | 1 | Transceiver event pulse |
| mon_evt_i | input | 1 | Monitor status change pulse |
| aux_evt_i | input | 4 | Auxiliary event pulses: wake, watchdog, timer 1, timer 2 |
| ci0_i | input | CI_W | C/I channel 0 value |
| ci1_i | input | CI_W | C/I channel 1 value |
| rd_en_i | input | 1 | One-cycle read strobe |
| rd_addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe (mask only) |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for rd_addr_i |
| irq_o | output | 1 | Masked interrupt line |

## Verification
Single isolated events on each source confirm the bit positions and the timing. Overlapping events from several sources show that a clearing read touches only its own latch. Repeated summary reads, and reads of unmapped addresses, with bits pending separate a non-destructive read from a destructive one. Clearing reads that coincide with a new event expose a clear-wins priority bug. C/I changes on one channel followed by a read of the other channel catch a merged flag. A narrow mask with several sources pending shows that the mask gates only irq_o and never the value read back.

// File: rtl/irq_summary_pkg.sv
package irq_summary_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_AUX  = 4;
  localparam int unsigned NUM_ONE  = 4;
  localparam int unsigned NUM_CI   = 2;
  localparam logic [DATA_W-1:0] MASK_RST = 8'hFC;

  typedef enum logic [ADDR_W-1:0] {
    A_SUM  = 4'd0,
    A_HDLC = 4'd1,
    A_SYNC = 4'd2,
    A_CI0  = 4'd3,
    A_CI1  = 4'd4,
    A_AUX  = 4'd5,
    A_TRX  = 4'd6,
    A_MON  = 4'd7,
    A_MASK = 4'd8
  } reg_addr_e;

  localparam int unsigned B_HDLC = 7;
  localparam int unsigned B_SYNC = 6;
  localparam int unsigned B_CI   = 5;
  localparam int unsigned B_AUX  = 4;
  localparam int unsigned B_TRX  = 3;
  localparam int unsigned B_MON  = 2;
endpackage

// File: rtl/irq_cor_latch.sv
module irq_cor_latch #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // set beats clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~{W{clr_i}}) | set_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/irq_ci_detect.sv
module irq_ci_detect #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o,
  output logic         chg_o
);
  logic [W-1:0] val_q;
  logic         chg_q;
  logic         diff;

  assign diff = (val_i != val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      chg_q <= 1'b0;
    end else begin
      val_q <= val_i;
      chg_q <= (chg_q & ~clr_i) | diff;
    end
  end

  assign val_o = val_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_summary_pkg::*;
#(
  parameter int unsigned CI_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hdlc_evt_i,
  input  logic                sync_evt_i,
  input  logic                trx_evt_i,
  input  logic                mon_evt_i,
  input  logic [NUM_AUX-1:0]  aux_evt_i,
  input  logic [CI_W-1:0]     ci0_i,
  input  logic [CI_W-1:0]     ci1_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                irq_o
);
  localparam int unsigned CI_VAL_W = DATA_W - 1;

  // single-source order: 0 hdlc, 1 sync, 2 trx, 3 mon
  logic [NUM_ONE-1:0]           one_evt, one_clr, one_q;
  logic [NUM_CI-1:0][CI_W-1:0]  ci_in, ci_val;
  logic [NUM_CI-1:0]            ci_clr, ci_chg;
  logic [NUM_AUX-1:0]           aux_q;
  logic                         aux_clr;
  logic [DATA_W-1:0]            mask_q;
  logic [DATA_W-1:0]            summary;

  function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a,
                               input reg_addr_e r);
    return en && (a == r);
  endfunction

  assign one_evt = {mon_evt_i, trx_evt_i, sync_evt_i, hdlc_evt_i};
  assign one_clr = {hit(rd_en_i, rd_addr_i, A_MON), hit(rd_en_i, rd_addr_i, A_TRX),
                    hit(rd_en_i, rd_addr_i, A_SYNC), hit(rd_en_i, rd_addr_i, A_HDLC)};
  assign ci_in   = {ci1_i, ci0_i};
  assign ci_clr  = {hit(rd_en_i, rd_addr_i, A_CI1), hit(rd_en_i, rd_addr_i, A_CI0)};
  assign aux_clr = hit(rd_en_i, rd_addr_i, A_AUX);

  for (genvar g = 0; g < NUM_ONE; g++) begin : g_one
    irq_cor_latch #(.W(1)) u_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (one_evt[g]),
      .clr_i  (one_clr[g]),
      .q_o    (one_q[g])
    );
  end

  for (genvar g = 0; g < NUM_CI; g++) begin : g_ci
    irq_ci_detect #(.W(CI_W)) u_ci (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .val_i  (ci_in[g]),
      .clr_i  (ci_clr[g]),
      .val_o  (ci_val[g]),
      .chg_o  (ci_chg[g])
    );
  end

  irq_cor_latch #(.W(NUM_AUX)) u_aux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (aux_evt_i),
    .clr_i  (aux_clr),
    .q_o    (aux_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              mask_q <= MASK_RST;
    else if (hit(wr_en_i, rd_addr_i, A_MASK)) mask_q <= wr_data_i;
  end

  always_comb begin
    summary         = '0;
    summary[B_HDLC] = one_q[0];
    summary[B_SYNC] = one_q[1];
    summary[B_CI]   = |ci_chg;
    summary[B_AUX]  = |aux_q;
    summary[B_TRX]  = one_q[2];
    summary[B_MON]  = one_q[3];
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_SUM:  rd_data_o = summary;
      A_HDLC: rd_data_o = DATA_W'(one_q[0]);
      A_SYNC: rd_data_o = DATA_W'(one_q[1]);
      A_CI0:  rd_data_o = {ci_chg[0], CI_VAL_W'(ci_val[0])};
      A_CI1:  rd_data_o = {ci_chg[1], CI_VAL_W'(ci_val[1])};
      A_AUX:  rd_data_o = DATA_W'(aux_q);
      A_TRX:  rd_data_o = DATA_W'(one_q[2]);
      A_MON:  rd_data_o = DATA_W'(one_q[3]);
      A_MASK: rd_data_o = mask_q;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = |(summary & mask_q);
endmodule

// File: rtl/irq_summary_chk.sv
module irq_summary_chk
  import irq_summary_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic               hdlc_evt_i,
  input logic [NUM_AUX-1:0] aux_evt_i,
  input logic               irq_o,
  input logic [DATA_W-1:0]  summary_i
);
  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdlc_evt_i |=> summary_i[B_HDLC]);

  p_sum_read_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_SUM) |=> ((summary_i & $past(summary_i)) == $past(summary_i)));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_HDLC && !hdlc_evt_i) |=> !summary_i[B_HDLC]);

  p_collide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_HDLC && hdlc_evt_i) |=> summary_i[B_HDLC]);

  p_aux_or_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|aux_evt_i) |=> summary_i[B_AUX]);

  p_quiet_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (summary_i == '0) |-> !irq_o);
endmodule

bind irq_summary irq_summary_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .hdlc_evt_i (hdlc_evt_i),
  .aux_evt_i  (aux_evt_i),
  .irq_o      (irq_o),
  .summary_i  (summary)
);

// File: tb/irq_summary_tb_top.sv
`timescale 1ns/1ps
module irq_summary_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hdlc_evt = 0, sync_evt = 0, trx_evt = 0, mon_evt = 0;
  logic [3:0] aux_evt = '0, ci0 = '0, ci1 = '0;
  logic       rd_en = 0, wr_en = 0;
  logic [3:0] rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_hdlc, m_sync, m_trx, m_mon, m_ci0f, m_ci1f;
  bit [3:0] m_aux, m_ci0v, m_ci1v;
  bit [7:0] m_mask = 8'hFC;

  always #2.5 clk_i = ~clk_i;

  irq_summary dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hdlc_evt_i(hdlc_evt), .sync_evt_i(sync_evt), .trx_evt_i(trx_evt), .mon_evt_i(mon_evt),
    .aux_evt_i(aux_evt), .ci0_i(ci0), .ci1_i(ci1),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic bit [7:0] m_sum();
    return {m_hdlc, m_sync, m_ci0f | m_ci1f, |m_aux, m_trx, m_mon, 2'b00};
  endfunction

  function automatic bit [7:0] m_rd(input bit [3:0] a);
    case (a)
      4'd0: return m_sum();
      4'd1: return {7'd0, m_hdlc};
      4'd2: return {7'd0, m_sync};
      4'd3: return {m_ci0f, 3'd0, m_ci0v};
      4'd4: return {m_ci1f, 3'd0, m_ci1v};
      4'd5: return {4'd0, m_aux};
      4'd6: return {7'd0, m_trx};
      4'd7: return {7'd0, m_mon};
      4'd8: return m_mask;
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input string tag, input bit [7:0] act, input bit [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // compare before the edge, then advance the model with the inputs held at the edge
  task automatic cyc(input string tag);
    bit c0, c1;
    #1;
    check(tag, rd_data, m_rd(rd_addr), "rd_data");
    check(tag, {7'd0, irq}, {7'd0, |(m_sum() & m_mask)}, "irq");
    @(posedge clk_i);
    c0 = (ci0 != m_ci0v); c1 = (ci1 != m_ci1v);
    m_hdlc = hdlc_evt | (m_hdlc & !(rd_en && rd_addr == 1));
    m_sync = sync_evt | (m_sync & !(rd_en && rd_addr == 2));
    m_trx  = trx_evt  | (m_trx  & !(rd_en && rd_addr == 6));
    m_mon  = mon_evt  | (m_mon  & !(rd_en && rd_addr == 7));
    m_aux  = aux_evt  | (m_aux  & {4{!(rd_en && rd_addr == 5)}});
    m_ci0f = c0 | (m_ci0f & !(rd_en && rd_addr == 3));
    m_ci1f = c1 | (m_ci1f & !(rd_en && rd_addr == 4));
    m_ci0v = ci0; m_ci1v = ci1;
    if (wr_en && rd_addr == 8) m_mask = wr_data;
    #1;
    hdlc_evt = 0; sync_evt = 0; trx_evt = 0; mon_evt = 0; aux_evt = '0;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic rd(input bit [3:0] a, input string tag);
    rd_addr = a; rd_en = 1; cyc(tag);
  endtask

  task automatic look(input bit [3:0] a, input string tag);
    rd_addr = a; cyc(tag);
  endtask

  initial begin
    #3;
    check("R1", rd_data, 8'h00, "reset summary");
    check("R1", {7'd0, irq}, 8'h00, "reset irq");
    rd_addr = 8; #1;
    check("R1", rd_data, 8'hFC, "reset mask");
    rd_addr = 0;
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    look(0, "R1");

    // R2: each source alone
    hdlc_evt = 1; look(0, "R2"); look(0, "R2"); rd(1, "R2"); look(0, "R2");
    sync_evt = 1; look(0, "R2"); rd(2, "R2");
    trx_evt  = 1; look(0, "R2"); rd(6, "R2");
    mon_evt  = 1; look(0, "R2"); rd(7, "R2");
    aux_evt  = 4'b0100; look(0, "R2"); rd(5, "R2"); look(0, "R2");

    // R3: summary reads are non-destructive
    hdlc_evt = 1; trx_evt = 1; aux_evt = 4'b0001; look(0, "R3");
    for (int i = 0; i < 4; i++) rd(0, "R3");
    look(1, "R3"); look(5, "R3");

    // R4: one clearing read leaves others
    sync_evt = 1; mon_evt = 1; look(0, "R4");
    rd(6, "R4"); look(0, "R4"); rd(1, "R4"); look(0, "R4");
    rd(2, "R4"); rd(7, "R4"); look(0, "R4");

    // R5: event at the clearing read survives
    hdlc_evt = 1; look(0, "R5");
    hdlc_evt = 1; rd(1, "R5"); look(0, "R5"); look(1, "R5");
    aux_evt = 4'b1000; rd(5, "R5"); look(5, "R5");
    mon_evt = 1; rd(7, "R5"); look(7, "R5");
    rd(1, "R5"); rd(5, "R5"); rd(7, "R5"); rd(6, "R5"); look(0, "R5");

    // R6: four aux sources
    for (int k = 0; k < 4; k++) begin
      aux_evt = 4'(1 << k); look(5, "R6"); look(0, "R6"); rd(5, "R6"); look(0, "R6");
    end
    aux_evt = 4'b0011; look(5, "R6"); aux_evt = 4'b1000; look(5, "R6");
    rd(5, "R6"); look(5, "R6"); look(0, "R6");

    // R7: C/I change detection per channel
    ci0 = 4'hA; look(3, "R7"); look(0, "R7"); look(3, "R7");
    rd(4, "R7"); look(0, "R7"); rd(3, "R7"); look(0, "R7");
    ci1 = 4'h5; look(4, "R7"); ci0 = 4'h3; look(0, "R7");
    rd(3, "R7"); look(0, "R7"); look(4, "R7"); rd(4, "R7"); look(0, "R7");
    look(3, "R7"); look(4, "R7");
    ci0 = 4'h3; look(0, "R7");

    // R8: mask gates only irq
    rd_addr = 8; wr_data = 8'h80; wr_en = 1; cyc("R8"); look(8, "R8");
    sync_evt = 1; look(0, "R8"); look(0, "R8");
    hdlc_evt = 1; look(0, "R8"); look(0, "R8");
    rd(1, "R8"); look(0, "R8");
    rd_addr = 8; wr_data = 8'h40; wr_en = 1; cyc("R8"); look(0, "R8");
    rd_addr = 8; wr_data = 8'h00; wr_en = 1; cyc("R8"); look(0, "R8"); rd(2, "R8");
    rd_addr = 8; wr_data = 8'hFC; wr_en = 1; cyc("R8"); look(8, "R8");

    // R9: unmapped addresses
    trx_evt = 1; aux_evt = 4'b0010; ci1 = 4'h9; look(0, "R9");
    for (int a = 9; a < 16; a++) rd(4'(a), "R9");
    look(0, "R9"); look(6, "R9"); look(5, "R9"); look(4, "R9");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule